// File: doc/BRIEF.md
# Strided Vector Memory Access Unit with Interleaved Banks

This block moves one vector between a vector register and a word-interleaved banked memory. A single start pulse supplies a base word address, a stride, an element count and a direction (load or store). From then on the unit produces one element address per cycle. Each address is the previous one plus the stride. Every address is routed to the bank chosen by its low address bits. All banks share one request path and one return path. A bank that is still serving an earlier access holds up issue, and the element sequence never skips or reorders. When the stride has no common factor with the bank count, the unit sustains one element per cycle. A stride of zero, or a stride that shares a factor with the bank count, makes issue wait on the busy bank.

Loads write each returned word into the internal vector register at its element index. Stores read the vector register at the element index and write that word to memory. In both directions each finished element appears on a tagged output with its index and data. A one-cycle completion pulse follows the final element. The banks are behavioural models with a fixed access time.

Top module: `vec_stride_mover`

## Requirements
- R1: Element i uses word address (base + i*stride) mod 2^AW (AW = 10). Its request appears as a one-hot strobe on bank_req_o, at bit position address mod 16 (address bits [3:0]). No more than one strobe is high in any cycle.
- R2: The number of elements moved equals len_i, clipped to 64. A length of zero moves nothing and raises done_o on the second cycle after the start edge.
- R3: A bank access lasts 11 cycles. A bank takes a new request no earlier than 11 cycles after its previous one.
- R4: At most one element completes per cycle. An element issued in cycle t completes on elem_valid_o 11 cycles later.
- R5: With a stride that is odd and a count L of at least one, requests go out in the L cycles after the start edge. done_o then rises L+12 cycles after the start edge.
- R6: When the target bank is busy, issue waits. No element is skipped or reordered, so elem_idx_o counts 0,1,2,… A zero stride issues one element every 11 cycles.
- R7: For a load, elem_data_o carries the memory word, and that word is written into the vector register at elem_idx_o. For a store, elem_data_o carries the vector-register word at elem_idx_o, and that word is written to memory. After reset, memory word w holds w XOR 0xA5A50000 and every vector-register element holds 0.
- R8: done_o is high for exactly one cycle, the cycle after the last elem_valid_o. busy_o is high from the start edge until the edge after done_o.
- R9: start_i is ignored while busy_o is high. The running transfer's addresses, data and completion time do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| dir_i | input | 1 | 0 = load into vector register, 1 = store from it |
| base_i | input | AW | First word address |
| stride_i | input | AW | Address increment per element |
| len_i | input | LENW | Element count, clipped to VLMAX |
| busy_o | output | 1 | Transfer in progress |
| bank_req_o | output | NBANK | One-hot request strobe per bank |
| elem_valid_o | output | 1 | An element finished this cycle |
| elem_idx_o | output | IDXW | Index of the finished element |
| elem_data_o | output | DW | Loaded or stored word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A bank can finish one access and accept the next in the same cycle. That cycle also carries a new request and an older completion on the shared return path. Zero and multiple-of-16 strides provoke this case, and so do strides of 2, 4 and 8. The bench sweeps every stride from 0 to 17 against an arithmetic schedule that takes the latest of "previous issue plus one" and "bank free time". In every cycle it compares the request strobe, the tag, the data and the completion pulse with that schedule. Stores followed by loads of the same region show that the returned data matches writes made in that order.

// File: rtl/vsm_pkg.sv
// Shared definitions for the strided vector memory access unit.
// Assumes: nothing beyond the enum below is shared.
package vsm_pkg;
    typedef enum logic {
        XFER_LOAD  = 1'b0,
        XFER_STORE = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/vsm_agu.sv
// Address generator and issue control. Holds one transfer's
// parameters, advances the address by the stride each time an element
// issues, and waits while the target bank is busy.
// Assumes: NBANK is a power of two; done_i comes from the collector.
module vsm_agu #(
    parameter int AW    = 10,
    parameter int NBANK = 16,
    parameter int VLMAX = 64,
    localparam int BANKW = $clog2(NBANK),
    localparam int LENW  = $clog2(VLMAX + 1),
    localparam int IDXW  = $clog2(VLMAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dir_i,
    input  logic [AW-1:0]    base_i,
    input  logic [AW-1:0]    stride_i,
    input  logic [LENW-1:0]  len_i,
    input  logic             done_i,
    input  logic [NBANK-1:0] bank_busy_i,
    output logic             busy_o,
    output logic             accept_o,
    output logic [NBANK-1:0] req_bank_o,
    output logic [AW-1:0]    req_addr_o,
    output logic [IDXW-1:0]  req_idx_o,
    output logic             dir_o,
    output logic [LENW-1:0]  len_o,
    output logic             zero_len_o
);
    logic             run_q;
    logic [LENW-1:0]  idx_q;
    logic [LENW-1:0]  len_q;
    logic [AW-1:0]    addr_q;
    logic [AW-1:0]    stride_q;
    logic             dir_q;
    logic             zl_q;
    logic [LENW-1:0]  len_eff;
    logic [BANKW-1:0] tgt;
    logic             pending;
    logic             issue;

    // clip the requested count to the register capacity
    always_comb len_eff = (len_i > LENW'(VLMAX)) ? LENW'(VLMAX) : len_i;

    // decide whether the current element may go out this cycle
    always_comb begin
        accept_o = start_i && !run_q;
        tgt      = addr_q[BANKW-1:0];
        pending  = run_q && (idx_q < len_q);
        issue    = pending && !bank_busy_i[tgt];
    end

    // one-hot strobe toward the selected bank
    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_req
            assign req_bank_o[b] = issue && (tgt == BANKW'(b));
        end
    endgenerate

    // transfer state: capture on start, advance on issue, end on done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            idx_q    <= '0;
            len_q    <= '0;
            addr_q   <= '0;
            stride_q <= '0;
            dir_q    <= 1'b0;
            zl_q     <= 1'b0;
        end else begin
            zl_q <= accept_o && (len_eff == '0);
            if (accept_o) begin
                run_q    <= 1'b1;
                idx_q    <= '0;
                len_q    <= len_eff;
                addr_q   <= base_i;
                stride_q <= stride_i;
                dir_q    <= dir_i;
            end else begin
                if (issue) begin
                    idx_q  <= idx_q + 1'b1;
                    addr_q <= addr_q + stride_q;
                end
                if (done_i) run_q <= 1'b0;
            end
        end
    end

    assign busy_o     = run_q;
    assign req_addr_o = addr_q;
    assign req_idx_o  = idx_q[IDXW-1:0];
    assign dir_o      = dir_q;
    assign len_o      = len_q;
    assign zero_len_o = zl_q;

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !issue) |=> $stable(addr_q) && $stable(idx_q));
    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && start_i) |=> $stable(len_q) && $stable(dir_q) && $stable(stride_q));
    // R1
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_bank_o));
endmodule

// File: rtl/vsm_bank.sv
// Behavioural bank model with a fixed access time of LAT cycles.
// A request is captured at once (read or write), the bank stays busy
// and reports the result in the final cycle of the access, when it
// can already take the next request.
// Assumes: LAT >= 2; the issuer honours busy_o.
module vsm_bank #(
    parameter int            AW       = 10,
    parameter int            DW       = 32,
    parameter int            NBANK    = 16,
    parameter int            LAT      = 11,
    parameter int            IDXW     = 6,
    parameter int            BANK_ID  = 0,
    parameter logic [DW-1:0] INIT_PAT = 32'hA5A5_0000,
    localparam int BANKW = $clog2(NBANK),
    localparam int ROWW  = AW - BANKW,
    localparam int DEPTH = 1 << ROWW,
    localparam int CNTW  = $clog2(LAT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic            we_i,
    input  logic [ROWW-1:0] row_i,
    input  logic [IDXW-1:0] idx_i,
    input  logic [DW-1:0]   wdata_i,
    output logic            busy_o,
    output logic            resp_v_o,
    output logic [IDXW-1:0] resp_idx_o,
    output logic [DW-1:0]   resp_data_o
);
    logic [DW-1:0]   mem [DEPTH];
    logic [CNTW-1:0] cnt_q;
    logic [IDXW-1:0] tag_q;
    logic [DW-1:0]   data_q;

    // remaining access time: reload on request, else count down
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (req_i)        cnt_q <= CNTW'(LAT);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // storage and captured result of the access in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < DEPTH; r++)
                mem[r] <= DW'(r * NBANK + BANK_ID) ^ INIT_PAT;
            tag_q  <= '0;
            data_q <= '0;
        end else if (req_i) begin
            tag_q  <= idx_i;
            data_q <= we_i ? wdata_i : mem[row_i];
            if (we_i) mem[row_i] <= wdata_i;
        end
    end

    assign busy_o      = cnt_q > CNTW'(1);
    assign resp_v_o    = cnt_q == CNTW'(1);
    assign resp_idx_o  = tag_q;
    assign resp_data_o = data_q;

    // R3
    req_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |-> (cnt_q <= CNTW'(1)));
endmodule

// File: rtl/vsm_collect.sv
// Completion path: selects the single finishing bank, registers the
// tagged element, writes loads into the vector register, counts
// completions and raises the done pulse after the last one.
// Also serves the store read of the vector register.
// Assumes: at most one bank reports per cycle.
module vsm_collect #(
    parameter int DW    = 32,
    parameter int NBANK = 16,
    parameter int VLMAX = 64,
    localparam int IDXW = $clog2(VLMAX),
    localparam int LENW = $clog2(VLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             dir_i,
    input  logic [LENW-1:0]  len_i,
    input  logic             zero_len_i,
    input  logic [NBANK-1:0] resp_v_i,
    input  logic [IDXW-1:0]  resp_idx_i  [NBANK],
    input  logic [DW-1:0]    resp_data_i [NBANK],
    input  logic [IDXW-1:0]  rd_idx_i,
    output logic [DW-1:0]    rd_data_o,
    output logic             elem_valid_o,
    output logic [IDXW-1:0]  elem_idx_o,
    output logic [DW-1:0]    elem_data_o,
    output logic             done_o
);
    logic [DW-1:0]   vreg [VLMAX];
    logic [IDXW-1:0] sel_idx;
    logic [DW-1:0]   sel_data;
    logic            any_v;
    logic            last;
    logic [LENW-1:0] cnt_q;
    logic            last_q;
    logic            done_q;

    // merge the finishing bank onto the shared return path
    always_comb begin
        sel_idx  = '0;
        sel_data = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (resp_v_i[b]) begin
                sel_idx  = sel_idx  | resp_idx_i[b];
                sel_data = sel_data | resp_data_i[b];
            end
        end
        any_v = |resp_v_i;
        last  = any_v && (cnt_q == LENW'(len_i - 1'b1));
    end

    // completion counter for the running transfer
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clear_i)  cnt_q <= '0;
        else if (any_v)    cnt_q <= cnt_q + 1'b1;
    end

    // registered element output and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elem_valid_o <= 1'b0;
            elem_idx_o   <= '0;
            elem_data_o  <= '0;
            last_q       <= 1'b0;
            done_q       <= 1'b0;
        end else begin
            elem_valid_o <= any_v;
            elem_idx_o   <= sel_idx;
            elem_data_o  <= sel_data;
            last_q       <= last;
            done_q       <= last_q || zero_len_i;
        end
    end

    // vector register: loads write at the returned element index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < VLMAX; e++) vreg[e] <= '0;
        end else if (any_v && (dir_i == vsm_pkg::XFER_LOAD)) begin
            vreg[sel_idx] <= sel_data;
        end
    end

    assign rd_data_o = vreg[rd_idx_i];
    assign done_o    = done_q;

    // R4
    single_completion_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(resp_v_i));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/vec_stride_mover.sv
// Top level: strided vector load/store engine over NBANK word-interleaved
// banks. Bank = low address bits, row = the remaining bits.
// Assumes: NBANK a power of two, LAT >= 2, AW > log2(NBANK).
module vec_stride_mover #(
    parameter int AW    = 10,
    parameter int DW    = 32,
    parameter int NBANK = 16,
    parameter int LAT   = 11,
    parameter int VLMAX = 64,
    localparam int BANKW = $clog2(NBANK),
    localparam int LENW  = $clog2(VLMAX + 1),
    localparam int IDXW  = $clog2(VLMAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dir_i,
    input  logic [AW-1:0]    base_i,
    input  logic [AW-1:0]    stride_i,
    input  logic [LENW-1:0]  len_i,
    output logic             busy_o,
    output logic [NBANK-1:0] bank_req_o,
    output logic             elem_valid_o,
    output logic [IDXW-1:0]  elem_idx_o,
    output logic [DW-1:0]    elem_data_o,
    output logic             done_o
);
    logic             accept;
    logic [AW-1:0]    req_addr;
    logic [IDXW-1:0]  req_idx;
    logic             dir_q;
    logic [LENW-1:0]  len_q;
    logic             zero_len;
    logic [NBANK-1:0] bank_busy;
    logic [NBANK-1:0] resp_v;
    logic [IDXW-1:0]  resp_idx  [NBANK];
    logic [DW-1:0]    resp_data [NBANK];
    logic [DW-1:0]    st_data;

    vsm_agu #(.AW(AW), .NBANK(NBANK), .VLMAX(VLMAX)) u_agu (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .dir_i       (dir_i),
        .base_i      (base_i),
        .stride_i    (stride_i),
        .len_i       (len_i),
        .done_i      (done_o),
        .bank_busy_i (bank_busy),
        .busy_o      (busy_o),
        .accept_o    (accept),
        .req_bank_o  (bank_req_o),
        .req_addr_o  (req_addr),
        .req_idx_o   (req_idx),
        .dir_o       (dir_q),
        .len_o       (len_q),
        .zero_len_o  (zero_len)
    );

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            vsm_bank #(
                .AW(AW), .DW(DW), .NBANK(NBANK), .LAT(LAT),
                .IDXW(IDXW), .BANK_ID(b)
            ) u_bank (
                .clk         (clk),
                .rst_n       (rst_n),
                .req_i       (bank_req_o[b]),
                .we_i        (dir_q),
                .row_i       (req_addr[AW-1:BANKW]),
                .idx_i       (req_idx),
                .wdata_i     (st_data),
                .busy_o      (bank_busy[b]),
                .resp_v_o    (resp_v[b]),
                .resp_idx_o  (resp_idx[b]),
                .resp_data_o (resp_data[b])
            );
        end
    endgenerate

    vsm_collect #(.DW(DW), .NBANK(NBANK), .VLMAX(VLMAX)) u_collect (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (accept),
        .dir_i        (dir_q),
        .len_i        (len_q),
        .zero_len_i   (zero_len),
        .resp_v_i     (resp_v),
        .resp_idx_i   (resp_idx),
        .resp_data_i  (resp_data),
        .rd_idx_i     (req_idx),
        .rd_data_o    (st_data),
        .elem_valid_o (elem_valid_o),
        .elem_idx_o   (elem_idx_o),
        .elem_data_o  (elem_data_o),
        .done_o       (done_o)
    );

    // R8
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    // R1
    req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_req_o != '0) |-> busy_o);
endmodule

// File: tb/test_vec_stride_mover.sv
module test_vec_stride_mover;
    localparam int AW = 10, NB = 16, LAT = 11, VL = 64;
    localparam int WORDS = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dir_i = 1'b0;
    logic [9:0]  base_i = '0;
    logic [9:0]  stride_i = '0;
    logic [6:0]  len_i = '0;
    logic        busy_o;
    logic [15:0] bank_req_o;
    logic        elem_valid_o;
    logic [5:0]  elem_idx_o;
    logic [31:0] elem_data_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] sh_mem [WORDS];
    logic [31:0] sh_vreg [VL];

    always #5 clk = ~clk;

    vec_stride_mover i_vec_stride_mover (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
        .base_i(base_i), .stride_i(stride_i), .len_i(len_i),
        .busy_o(busy_o), .bank_req_o(bank_req_o), .elem_valid_o(elem_valid_o),
        .elem_idx_o(elem_idx_o), .elem_data_o(elem_data_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Runs one transfer and compares every cycle against a computed schedule.
    task automatic run_op(input bit d, input int base, input int stride,
                          input int len, input bit poke);
        int L, done_k, prev;
        int t_iss [VL];
        int adr [VL];
        logic [31:0] edat [VL];
        int bfree [NB];
        L = (len > VL) ? VL : len;
        prev = 0;
        for (int b = 0; b < NB; b++) bfree[b] = 0;
        for (int i = 0; i < L; i++) begin
            int t;
            adr[i] = (base + i * stride) % WORDS;
            t = prev + 1;
            if (bfree[adr[i] % NB] > t) t = bfree[adr[i] % NB];
            t_iss[i] = t;
            bfree[adr[i] % NB] = t + LAT;
            prev = t;
            if (d) begin
                edat[i] = sh_vreg[i];
                sh_mem[adr[i]] = sh_vreg[i];
            end else begin
                edat[i] = sh_mem[adr[i]];
                sh_vreg[i] = sh_mem[adr[i]];
            end
        end
        done_k = (L == 0) ? 1 : t_iss[L-1] + LAT + 1;
        if (L > 0 && (stride % 2) == 1)  // R5 expected closed form
            chk(done_k == L + LAT + 1, "R5", "schedule length", done_k, L + LAT + 1);
        @(negedge clk);
        start_i = 1'b1; dir_i = d; base_i = AW'(base);
        stride_i = AW'(stride); len_i = 7'(len);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
        for (int k = 0; k <= done_k + 2; k++) begin
            logic [15:0] ereq;
            int ev;
            if (k > 0) @(negedge clk);
            if (poke && k == 3) begin
                start_i = 1'b1; dir_i = ~d; base_i = 10'h155;
                stride_i = 10'd16; len_i = 7'd2;
            end else if (poke && k == 4) begin
                start_i = 1'b0;
            end
            ereq = '0;
            ev = -1;
            for (int i = 0; i < L; i++) begin
                if (t_iss[i] == k + 1) ereq = 16'(1) << (adr[i] % NB);
                if (t_iss[i] + LAT == k) ev = i;
            end
            if (bank_req_o != ereq)  // R1 R3 R6 bank and issue time
                chk(0, poke ? "R9" : "R1", "bank_req", bank_req_o, ereq);
            else if (ereq != 0) chk(1, "R1", "bank_req", bank_req_o, ereq);
            if (ev >= 0) begin
                chk(elem_valid_o == 1'b1, "R4", "elem_valid", elem_valid_o, 1);
                chk(elem_idx_o == 6'(ev), "R6", "elem_idx", elem_idx_o, ev);
                chk(elem_data_o == edat[ev], "R7", "elem_data", elem_data_o, edat[ev]);
            end else if (elem_valid_o) begin
                chk(0, "R4", "spurious elem_valid", elem_valid_o, 0);
            end
            if (done_o != (k == done_k))
                chk(0, "R8", "done timing", k, done_k);
            else if (k == done_k) chk(1, "R8", "done", done_o, 1);
        end
        chk(busy_o == 1'b0, "R8", "busy after done", busy_o, 0);
    endtask

    initial begin
        for (int w = 0; w < WORDS; w++) sh_mem[w] = 32'(w) ^ 32'hA5A5_0000;
        for (int e = 0; e < VL; e++) sh_vreg[e] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && elem_valid_o == 0 && bank_req_o == 0,
            "R8", "reset state", {busy_o, done_o, elem_valid_o}, 0);
        // store of the reset vector register: zeros reach memory (R7)
        run_op(1'b1, 900, 1, 4, 1'b0);
        // R1 R3 R5 R6: load sweep over all strides 0..17
        for (int s = 0; s <= 17; s++) run_op(1'b0, (s * 37) % WORDS, s, 24, 1'b0);
        // R2: full capacity and clipped length
        run_op(1'b0, 5, 1, 64, 1'b0);
        run_op(1'b0, 1000, 3, 100, 1'b0);
        // R2: zero length
        run_op(1'b0, 7, 1, 0, 1'b0);
        // R7: store a loaded vector elsewhere, then read it back
        run_op(1'b1, 100, 3, 64, 1'b0);
        run_op(1'b0, 100, 3, 64, 1'b0);
        // R6 R7: zero-stride store, last write wins
        run_op(1'b1, 333, 0, 5, 1'b0);
        run_op(1'b0, 333, 1, 3, 1'b0);
        // R9: start pulsed in the middle of a transfer
        run_op(1'b0, 40, 16, 6, 1'b1);
        // R3 R4: stride equal to bank count with wraparound
        run_op(1'b0, 1020, 16, 8, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule